// File: doc/BRIEF.md
# SPI Slave Peripheral with Overrun Detection

This block is a register-mapped SPI slave. An external master drives the serial clock, the slave select (active low) and the master-out data line. The block returns data on the master-in line together with an output-enable signal, which the chip pad uses as a tri-state control. All three incoming pins pass through two-flop synchronisers. Clock edges are then found in the system clock domain, so the system clock must run at least four times the serial clock rate. Frames are 8 bits wide, most significant bit first, in any of the four clock polarity and phase combinations.

Software works through three registers: control, status and data. When a frame completes, the block sets a done flag and can raise an interrupt. Software clears the flag with a two-step handshake: a status read while the flag is set, then a data read or write. Until that status read, data writes are ignored. A second frame that completes before the flag is cleared sets a sticky overrun bit. In that case the first received byte is kept and the second one is dropped.

When software may load the transmit shift register depends on the phase. With phase 0, a load is accepted only while the slave is deselected. With phase 1, the slave may stay selected across bytes, and a load is accepted in the gap between frames. A frame started without a new load sends back the byte received in the previous frame.

Top module: `spi_slave_ovr`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, `spi_miso_oe` is 0 and `irq` is 0.
- R2: With phase 0 (control bit 2 = 0), a loaded byte appears on `spi_miso` most significant bit first. The first bit is valid after select falls and before the first clock edge. The master samples on the leading edge.
- R3: With phase 1 (control bit 2 = 1), the first bit is presented on the first clock edge. The byte is returned most significant bit first, and the master samples on the trailing edge.
- R4: A completed frame puts the received byte (MSB first) in the data register (address 2) and sets status bit 7. `irq` equals status bit 7 AND control bit 3.
- R5: A status read (address 1) while bit 7 is set, followed by a data read or a data write, clears status bits 7 and 6. A data access without that prior status read leaves bit 7 set.
- R6: While bit 7 is set and no status read has occurred since, data writes are ignored. They neither load the shifter nor clear the flag.
- R7: A frame completing while bit 7 is set sets status bit 6 (overrun). The data register keeps the first byte. The R5 sequence clears bit 6.
- R8: With phase 0, a data write while select is low is ignored. With phase 1, a data write in the gap between frames with select held low is accepted for the next frame. A frame without a new load returns the previous received byte.
- R9: `spi_miso_oe` is 1 only while select is low and control bit 0 (enable) is 1.
- R10: Control bit 1 selects the idle clock level (polarity). Transfers work with both levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects take place at the clock edge) |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from `bus_addr` |
| irq | output | 1 | Interrupt request |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad |

## Verification
The hardest states to reach from the ports are those that depend on how software accesses interleave with frames. Examples are an inhibited write between completion and the status read, a second frame finishing before the handshake, and a load attempted mid-select in phase 0. The bench reaches them by scripting exact sequences: a write with no status read, two back-to-back frames under a continuous select, and a write issued after select falls. It then observes the effect through what the next frame returns on `spi_miso`. Random bytes in all four clock modes, with a random choice between the read and write clearing paths, cover the main function.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  // control bit positions
  localparam int CTL_EN   = 0;
  localparam int CTL_CPOL = 1;
  localparam int CTL_CPHA = 2;
  localparam int CTL_IRQ  = 3;
  localparam int CTL_W    = 4;

  // clock leaves its idle level
  function automatic logic is_lead(input logic prev, input logic cur, input logic cpol);
    return (prev == cpol) && (cur != cpol);
  endfunction

  // clock returns to its idle level
  function automatic logic is_trail(input logic prev, input logic cur, input logic cpol);
    return (prev != cpol) && (cur == cpol);
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_slv_shifter.sv
module spi_slv_shifter
  import spi_slv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          ss_s,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          miso,
  output logic          busy,
  output logic          frame_done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  function automatic logic [DW-1:0] shl(input logic [DW-1:0] v, input logic b);
    return {v[DW-2:0], b};
  endfunction

  logic          sck_d;
  logic [DW-1:0] sr;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          rbit;
  logic          miso_q;
  logic          active, lead, trail;

  assign active = en && !ss_s;
  assign lead   = active && is_lead(sck_d, sck_s, cpol);
  assign trail  = active && is_trail(sck_d, sck_s, cpol);

  assign frame_done = cpha ? (trail && pend && cnt == LAST) : (lead && cnt == LAST);
  assign rx_byte    = shl(sr, mosi_s);
  assign busy       = (cnt != '0) || pend;
  assign miso       = cpha ? miso_q : sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
      rbit   <= 1'b0;
      miso_q <= 1'b0;
    end else if (load) begin
      sr <= load_data;
    end else if (!active) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (!cpha) begin
      if (lead) begin
        if (cnt == LAST) begin
          sr   <= shl(sr, mosi_s);
          cnt  <= '0;
          pend <= 1'b0;
        end else begin
          rbit <= mosi_s;
          pend <= 1'b1;
          cnt  <= cnt + 1'b1;
        end
      end else if (trail && pend) begin
        sr   <= shl(sr, rbit);
        pend <= 1'b0;
      end
    end else begin
      if (lead) begin
        miso_q <= sr[DW-1];
        pend   <= 1'b1;
      end else if (trail && pend) begin
        sr   <= shl(sr, mosi_s);
        pend <= 1'b0;
        cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end

  // R4
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

endmodule

// File: rtl/spi_slv_regs.sv
module spi_slv_regs
  import spi_slv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ss_s,
  input  logic              busy,
  input  logic              frame_done,
  input  logic [DW-1:0]     rx_byte,
  output logic              en,
  output logic              cpol,
  output logic              cpha,
  output logic              irq,
  output logic              load,
  output logic [DW-1:0]     load_data
);
  logic [CTL_W-1:0] ctrl_q;
  logic             done_q, ovr_q, arm_q;
  logic [DW-1:0]    rxbuf_q;

  logic stat_rd, data_wr, data_rd, data_acc, clear, wr_block, load_ok;

  assign en   = ctrl_q[CTL_EN];
  assign cpol = ctrl_q[CTL_CPOL];
  assign cpha = ctrl_q[CTL_CPHA];
  assign irq  = done_q && ctrl_q[CTL_IRQ];

  assign stat_rd  = bus_rd && (bus_addr == REG_STAT);
  assign data_wr  = bus_wr && (bus_addr == REG_DATA);
  assign data_rd  = bus_rd && (bus_addr == REG_DATA);
  assign data_acc = data_wr || data_rd;
  assign clear    = arm_q && data_acc;
  assign wr_block = done_q && !arm_q;
  assign load_ok  = ss_s || (cpha && !busy);

  assign load      = data_wr && !wr_block && load_ok;
  assign load_data = bus_wdata;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: bus_rdata[CTL_W-1:0] = ctrl_q;
      REG_STAT: begin
        bus_rdata[DW-1] = done_q;
        bus_rdata[DW-2] = ovr_q;
      end
      REG_DATA: bus_rdata = rxbuf_q;
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
      arm_q   <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      if (bus_wr && bus_addr == REG_CTRL) ctrl_q <= bus_wdata[CTL_W-1:0];
      if (clear) begin
        done_q <= 1'b0;
        ovr_q  <= 1'b0;
        arm_q  <= 1'b0;
      end else if (stat_rd && done_q) begin
        arm_q <= 1'b1;
      end
      if (frame_done) begin
        if (done_q && !clear) begin
          ovr_q <= 1'b1;
        end else begin
          done_q  <= 1'b1;
          rxbuf_q <= rx_byte;
        end
      end
    end
  end

  // R4
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !done_q |=> done_q && rxbuf_q == $past(rx_byte));

  // R7
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && done_q && !clear |=> ovr_q && $stable(rxbuf_q));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !frame_done |=> !done_q && !ovr_q);

  // R6
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && wr_block |=> done_q);

endmodule

// File: rtl/spi_slave_ovr.sv
module spi_slave_ovr
  import spi_slv_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_ss_n,
  output logic              spi_miso,
  output logic              spi_miso_oe
);
  logic          sck_s, mosi_s, ss_s;
  logic          en, cpol, cpha;
  logic          load, busy, frame_done;
  logic [DW-1:0] load_data, rx_byte;

  spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_n), .d(spi_sck), .q(sck_s));
  spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));
  spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
    .clk(clk), .rst_n(rst_n), .d(spi_ss_n), .q(ss_s));

  spi_slv_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_s(ss_s), .busy(busy), .frame_done(frame_done), .rx_byte(rx_byte),
    .en(en), .cpol(cpol), .cpha(cpha), .irq(irq),
    .load(load), .load_data(load_data));

  spi_slv_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en(en), .cpol(cpol), .cpha(cpha),
    .sck_s(sck_s), .mosi_s(mosi_s), .ss_s(ss_s),
    .load(load), .load_data(load_data),
    .miso(spi_miso), .busy(busy),
    .frame_done(frame_done), .rx_byte(rx_byte));

  assign spi_miso_oe = en && !ss_s;

endmodule

// File: tb/spi_slave_ovr_test.sv
module spi_slave_ovr_test;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 6;
  localparam int DW = 8;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic irq, spi_sck = 0, spi_mosi = 0, spi_ss_n = 1, spi_miso, spi_miso_oe;

  int n_chk = 0, n_fail = 0;
  bit done_run = 0;
  logic cur_cpha;

  spi_slave_ovr #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ctrl_val(input bit e, input bit pol, input bit pha, input bit ie);
    return {4'b0, ie, pha, pol, e};
  endfunction

  function automatic logic [7:0] stat_val(input bit d, input bit o);
    return {d, o, 6'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic set_mode(input bit pol, input bit pha, input bit ie);
    spi_sck = pol;
    cur_cpha = pha;
    bus_write(A_CTRL, ctrl_val(1, pol, pha, ie));
    waitc(4);
  endtask

  // master side of one frame; select handled by the caller
  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    bit pol;
    pol = spi_sck;
    if (!cur_cpha) begin
      spi_mosi = mo[7];
      waitc(H);
      for (int i = 7; i >= 0; i--) begin
        mi[i] = spi_miso;
        spi_sck = ~pol;
        waitc(H);
        spi_sck = pol;
        if (i > 0) spi_mosi = mo[i-1];
        waitc(H);
      end
    end else begin
      for (int i = 7; i >= 0; i--) begin
        spi_sck = ~pol;
        spi_mosi = mo[i];
        waitc(H);
        mi[i] = spi_miso;
        spi_sck = pol;
        waitc(H);
      end
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=00 expected=01");
      report();
    end
  end

  initial begin
    logic [7:0] v, tx, mo, mi, mi2;
    bit need_load, ie, coin;
    int unsigned seed;
    seed = $urandom(32'd4242);
    cur_cpha = 0;
    waitc(5);
    rst_n = 1;
    waitc(2);

    // R1 reset state
    bus_read(A_CTRL, v); check(v == 8'h00, "R1 ctrl", v, 8'h00);
    bus_read(A_STAT, v); check(v == 8'h00, "R1 status", v, 8'h00);
    check(spi_miso_oe == 0, "R1 oe", {7'b0, spi_miso_oe}, 8'h00);
    check(irq == 0, "R1 irq", {7'b0, irq}, 8'h00);

    // R9 output enable
    set_mode(0, 0, 0);
    check(spi_miso_oe == 0, "R9 ss high", {7'b0, spi_miso_oe}, 8'h00);
    spi_ss_n = 0; waitc(H);
    check(spi_miso_oe == 1, "R9 selected", {7'b0, spi_miso_oe}, 8'h01);
    bus_write(A_CTRL, ctrl_val(0, 0, 0, 0)); waitc(2);
    check(spi_miso_oe == 0, "R9 disabled", {7'b0, spi_miso_oe}, 8'h00);
    spi_ss_n = 1; waitc(H);

    // random transfers in all four modes (R2 R3 R4 R5 R10)
    need_load = 1; tx = 8'h00;
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 5; k++) begin
        ie = $urandom % 2;
        set_mode(m[0], m[1], ie);
        if (need_load) begin
          tx = $urandom; bus_write(A_DATA, tx);
        end
        mo = $urandom;
        spi_ss_n = 0; waitc(H);
        if (!m[1]) check(spi_miso == tx[7], "R2 first bit before edge", {7'b0, spi_miso}, {7'b0, tx[7]});
        xfer(mo, mi);
        waitc(H); spi_ss_n = 1; waitc(H);
        check(mi == tx, m[1] ? "R3 R10 miso byte" : "R2 R10 miso byte", mi, tx);
        bus_read(A_STAT, v); check(v == stat_val(1, 0), "R4 done flag", v, stat_val(1, 0));
        check(irq == ie, "R4 irq", {7'b0, irq}, {7'b0, ie});
        coin = $urandom % 2;
        if (coin) begin
          bus_read(A_DATA, v); check(v == mo, "R4 rx byte", v, mo);
          bus_read(A_STAT, v); check(v == 8'h00, "R5 clear by read", v, 8'h00);
          need_load = 1;
        end else begin
          tx = $urandom; bus_write(A_DATA, tx);
          bus_read(A_STAT, v); check(v == 8'h00, "R5 clear by write", v, 8'h00);
          bus_read(A_DATA, v); check(v == mo, "R4 rx byte", v, mo);
          need_load = 0;
        end
      end
    end

    // R5 data access without prior status read does not clear
    set_mode(0, 0, 0);
    bus_write(A_DATA, 8'hA5);
    spi_ss_n = 0; waitc(H); xfer(8'h3C, mi); waitc(H); spi_ss_n = 1; waitc(H);
    bus_read(A_DATA, v); check(v == 8'h3C, "R5 rx", v, 8'h3C);
    bus_read(A_STAT, v); check(v == stat_val(1, 0), "R5 still set", v, stat_val(1, 0));
    bus_read(A_DATA, v);
    bus_read(A_STAT, v); check(v == 8'h00, "R5 cleared", v, 8'h00);

    // R6 inhibited write
    bus_write(A_DATA, 8'h5A);
    spi_ss_n = 0; waitc(H); xfer(8'hC3, mi); waitc(H); spi_ss_n = 1; waitc(H);
    check(mi == 8'h5A, "R2 loaded byte", mi, 8'h5A);
    bus_write(A_DATA, 8'h99);
    bus_read(A_STAT, v); check(v == stat_val(1, 0), "R6 flag kept", v, stat_val(1, 0));
    bus_read(A_DATA, v); check(v == 8'hC3, "R6 rx", v, 8'hC3);
    spi_ss_n = 0; waitc(H); xfer(8'h11, mi); waitc(H); spi_ss_n = 1; waitc(H);
    check(mi == 8'hC3, "R6 write ignored", mi, 8'hC3);
    bus_read(A_STAT, v); bus_read(A_DATA, v); check(v == 8'h11, "R4 rx", v, 8'h11);

    // R7 overrun, phase 1, continuous select
    set_mode(1, 1, 0);
    bus_write(A_DATA, 8'h0F);
    spi_ss_n = 0; waitc(H);
    xfer(8'hA1, mi); waitc(H);
    xfer(8'hB2, mi2); waitc(H);
    spi_ss_n = 1; waitc(H);
    check(mi == 8'h0F, "R3 first frame", mi, 8'h0F);
    check(mi2 == 8'hA1, "R8 echo", mi2, 8'hA1);
    bus_read(A_STAT, v); check(v == stat_val(1, 1), "R7 overrun", v, stat_val(1, 1));
    bus_read(A_DATA, v); check(v == 8'hA1, "R7 first kept", v, 8'hA1);
    bus_read(A_STAT, v); check(v == 8'h00, "R7 cleared", v, 8'h00);

    // R8 phase 0 write while selected ignored
    set_mode(0, 0, 0);
    spi_ss_n = 0; waitc(H);
    bus_write(A_DATA, 8'h77);
    xfer(8'hE4, mi); waitc(H); spi_ss_n = 1; waitc(H);
    check(mi == 8'hB2, "R8 cpha0 write ignored", mi, 8'hB2);
    bus_read(A_STAT, v); bus_read(A_DATA, v); check(v == 8'hE4, "R4 rx", v, 8'hE4);

    // R8 phase 1 write between frames with select low
    set_mode(0, 1, 0);
    bus_write(A_DATA, 8'h6D);
    spi_ss_n = 0; waitc(H);
    xfer(8'h01, mi); waitc(H);
    bus_read(A_STAT, v);
    bus_write(A_DATA, 8'h92);
    xfer(8'h02, mi2); waitc(H);
    spi_ss_n = 1; waitc(H);
    check(mi == 8'h6D, "R3 frame", mi, 8'h6D);
    check(mi2 == 8'h92, "R8 cpha1 load between frames", mi2, 8'h92);
    bus_read(A_STAT, v); check(v == stat_val(1, 0), "R8 no overrun", v, stat_val(1, 0));
    bus_read(A_DATA, v); check(v == 8'h02, "R4 rx", v, 8'h02);
    bus_read(A_STAT, v); check(v == 8'h00, "R5 cleared", v, 8'h00);

    done_run = 1;
    report();
  end
endmodule